// File: doc/BRIEF.md
# Thermal Sensor Code Translator

This block takes raw 12-bit readings from up to four on-die thermal sensors and turns each into a signed temperature in millidegrees Celsius. Each reading arrives with a one-cycle valid strobe, a channel number and a per-sample selector that picks the conversion law. The result leaves after a fixed three-cycle pipeline. It carries the channel number it came in with and a flag that marks readings which hold no data yet.

Two conversion laws are available. The linear law subtracts a scaled code from a configured intercept. The piecewise law has a steeper slope below the code 0x500, and that slope also depends on whether the channel is 0. A configured deviation is added once the chosen law has been applied, as a separate final term. A raw code of zero means the sensor has not produced a sample. Such a code gives no temperature.

All arithmetic is signed integer. Every division by ten truncates toward zero, so each law computes `intercept - trunc(code * k / 10) + DEVIATION`.

Top module: `tcode_xlate`

## Requirements
- R1: With `in_pw` = 0 and a nonzero code, `out_temp` = `LIN_OFFSET - trunc(code * LIN_SCALE / 10) + DEVIATION`.
- R2: With `in_pw` = 1 and a code of at least 0x500, `out_temp` = `223000 - trunc(code * 1191 / 10) + DEVIATION` on every channel.
- R3: With `in_pw` = 1, a nonzero code below 0x500 and channel 0, `out_temp` = `259000 - trunc(code * 1452 / 10) + DEVIATION`.
- R4: With `in_pw` = 1, a nonzero code below 0x500 and a channel other than 0, `out_temp` = `276000 - trunc(code * 1590 / 10) + DEVIATION`.
- R5: A code of zero gives a result with `out_nodata` = 1 and `out_temp` = 0 in either mode. Any nonzero code gives `out_nodata` = 0.
- R6: `DEVIATION` is added after the conversion law as its own term. With `DEVIATION` = 7000, every nonzero result is exactly 7000 above the bare law.
- R7: `out_valid` is high exactly three clock cycles after each cycle in which `in_valid` is high, and low otherwise. Back-to-back inputs give back-to-back results.
- R8: `out_chan` equals the `in_chan` of the sample that produced the result.
- R9: While `rst` is high, and on the first cycle after it falls, `out_valid` = 0, `out_nodata` = 0, `out_temp` = 0 and `out_chan` = 0.
- R10: In a cycle with `out_valid` = 0, `out_temp`, `out_chan` and `out_nodata` keep the values of the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A raw sample is present this cycle |
| in_chan | input | CHAN_W (2) | Sensor channel of the sample |
| in_code | input | CODE_W (12) | Raw sensor code, 0 = no data |
| in_pw | input | 1 | 0 = linear law, 1 = piecewise law |
| out_valid | output | 1 | Result present this cycle |
| out_chan | output | CHAN_W (2) | Channel of the result |
| out_temp | output | RES_W (32) | Signed temperature in millidegrees Celsius |
| out_nodata | output | 1 | The result came from a zero code |

## Verification
The bench sweeps every code in both modes on all four channels. This covers the edge at 0x4FF/0x500, where a wrong compare would apply the low slope one code too far or switch too early. It also covers the channel-0 split, where a mistaken channel decode would report channel 1's steep slope on channel 0. Zero codes are checked for the no-data flag and a cleared temperature, since a design that skipped the test would report the full intercept as a temperature. Idle gaps are placed between samples to catch results that arrive a cycle early or late, or outputs that drift while nothing is valid.

// File: rtl/tcode_pkg.sv
package tcode_pkg;
  // Piecewise law: break code, high-range slope/intercept, low-range per channel
  localparam int PW_BREAK = 'h500;
  localparam int PW_HI_K  = 1191;
  localparam int PW_HI_B  = 223000;
  localparam int PW_LO0_K = 1452;
  localparam int PW_LO0_B = 259000;
  localparam int PW_LOX_K = 1590;
  localparam int PW_LOX_B = 276000;
  localparam int DIVISOR  = 10;
endpackage

// File: rtl/tcode_coef_sel.sv
module tcode_coef_sel
  import tcode_pkg::*;
#(
  parameter int CODE_W     = 12,
  parameter int CHAN_W     = 2,
  parameter int RES_W      = 32,
  parameter int LIN_OFFSET = 217000,
  parameter int LIN_SCALE  = 1211
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    i_vld,
  input  logic [CHAN_W-1:0]       i_chan,
  input  logic [CODE_W-1:0]       i_code,
  input  logic                    i_pw,
  output logic                    s1_vld,
  output logic [CHAN_W-1:0]       s1_chan,
  output logic [CODE_W-1:0]       s1_code,
  output logic signed [RES_W-1:0] s1_k,
  output logic signed [RES_W-1:0] s1_b,
  output logic                    s1_zero
);
  localparam logic [CODE_W-1:0]       BRK   = CODE_W'(PW_BREAK);
  localparam logic signed [RES_W-1:0] LK    = RES_W'(LIN_SCALE);
  localparam logic signed [RES_W-1:0] LB    = RES_W'(LIN_OFFSET);
  localparam logic signed [RES_W-1:0] HK    = RES_W'(PW_HI_K);
  localparam logic signed [RES_W-1:0] HB    = RES_W'(PW_HI_B);
  localparam logic signed [RES_W-1:0] L0K   = RES_W'(PW_LO0_K);
  localparam logic signed [RES_W-1:0] L0B   = RES_W'(PW_LO0_B);
  localparam logic signed [RES_W-1:0] LXK   = RES_W'(PW_LOX_K);
  localparam logic signed [RES_W-1:0] LXB   = RES_W'(PW_LOX_B);

  logic signed [RES_W-1:0] k_c, b_c;

  always_comb begin
    if (!i_pw) begin
      k_c = LK;  b_c = LB;
    end else if (i_code >= BRK) begin
      k_c = HK;  b_c = HB;
    end else if (i_chan == '0) begin
      k_c = L0K; b_c = L0B;
    end else begin
      k_c = LXK; b_c = LXB;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_chan <= '0;
      s1_code <= '0;
      s1_k    <= '0;
      s1_b    <= '0;
      s1_zero <= 1'b0;
    end else begin
      s1_vld <= i_vld;
      if (i_vld) begin
        s1_chan <= i_chan;
        s1_code <= i_code;
        s1_k    <= k_c;
        s1_b    <= b_c;
        s1_zero <= (i_code == '0);
      end
    end
  end
endmodule

// File: rtl/tcode_scale.sv
module tcode_scale
  import tcode_pkg::*;
#(
  parameter int CODE_W    = 12,
  parameter int CHAN_W    = 2,
  parameter int RES_W     = 32,
  parameter int DEVIATION = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    s1_vld,
  input  logic [CHAN_W-1:0]       s1_chan,
  input  logic [CODE_W-1:0]       s1_code,
  input  logic signed [RES_W-1:0] s1_k,
  input  logic signed [RES_W-1:0] s1_b,
  input  logic                    s1_zero,
  output logic                    o_vld,
  output logic [CHAN_W-1:0]       o_chan,
  output logic signed [RES_W-1:0] o_temp,
  output logic                    o_nodata
);
  localparam logic signed [RES_W-1:0] DIV_V = RES_W'(DIVISOR);
  localparam logic signed [RES_W-1:0] DEV_V = RES_W'(DEVIATION);

  logic                    s2_vld, s2_zero;
  logic [CHAN_W-1:0]       s2_chan;
  logic signed [RES_W-1:0] s2_prod, s2_b;
  logic signed [RES_W-1:0] code_ext;

  assign code_ext = signed'({{(RES_W-CODE_W){1'b0}}, s1_code});

  // Stage 2: product
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_vld  <= 1'b0;
      s2_zero <= 1'b0;
      s2_chan <= '0;
      s2_prod <= '0;
      s2_b    <= '0;
    end else begin
      s2_vld <= s1_vld;
      if (s1_vld) begin
        s2_zero <= s1_zero;
        s2_chan <= s1_chan;
        s2_prod <= code_ext * s1_k;
        s2_b    <= s1_b;
      end
    end
  end

  // Stage 3: truncating divide, intercept, then deviation as a separate term
  logic signed [RES_W-1:0] base_c;
  assign base_c = s2_b - (s2_prod / DIV_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld    <= 1'b0;
      o_chan   <= '0;
      o_temp   <= '0;
      o_nodata <= 1'b0;
    end else begin
      o_vld <= s2_vld;
      if (s2_vld) begin
        o_chan   <= s2_chan;
        o_nodata <= s2_zero;
        o_temp   <= s2_zero ? '0 : base_c + DEV_V;
      end
    end
  end
endmodule

// File: rtl/tcode_xlate.sv
module tcode_xlate #(
  parameter int CODE_W     = 12,
  parameter int CHAN_N     = 4,
  parameter int RES_W      = 32,
  parameter int LIN_OFFSET = 217000,
  parameter int LIN_SCALE  = 1211,
  parameter int DEVIATION  = 0,
  localparam int CHAN_W    = (CHAN_N > 1) ? $clog2(CHAN_N) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [CHAN_W-1:0]       in_chan,
  input  logic [CODE_W-1:0]       in_code,
  input  logic                    in_pw,
  output logic                    out_valid,
  output logic [CHAN_W-1:0]       out_chan,
  output logic signed [RES_W-1:0] out_temp,
  output logic                    out_nodata
);
  logic                    s1_vld, s1_zero;
  logic [CHAN_W-1:0]       s1_chan;
  logic [CODE_W-1:0]       s1_code;
  logic signed [RES_W-1:0] s1_k, s1_b;

  tcode_coef_sel #(
    .CODE_W(CODE_W), .CHAN_W(CHAN_W), .RES_W(RES_W),
    .LIN_OFFSET(LIN_OFFSET), .LIN_SCALE(LIN_SCALE)
  ) u_sel (
    .clk(clk), .rst(rst),
    .i_vld(in_valid), .i_chan(in_chan), .i_code(in_code), .i_pw(in_pw),
    .s1_vld(s1_vld), .s1_chan(s1_chan), .s1_code(s1_code),
    .s1_k(s1_k), .s1_b(s1_b), .s1_zero(s1_zero)
  );

  tcode_scale #(
    .CODE_W(CODE_W), .CHAN_W(CHAN_W), .RES_W(RES_W), .DEVIATION(DEVIATION)
  ) u_scale (
    .clk(clk), .rst(rst),
    .s1_vld(s1_vld), .s1_chan(s1_chan), .s1_code(s1_code),
    .s1_k(s1_k), .s1_b(s1_b), .s1_zero(s1_zero),
    .o_vld(out_valid), .o_chan(out_chan), .o_temp(out_temp), .o_nodata(out_nodata)
  );
endmodule

// File: rtl/tcode_xlate_chk.sv
module tcode_xlate_chk #(
  parameter int CODE_W = 12,
  parameter int CHAN_W = 2,
  parameter int RES_W  = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [CHAN_W-1:0]       in_chan,
  input logic [CODE_W-1:0]       in_code,
  input logic                    out_valid,
  input logic [CHAN_W-1:0]       out_chan,
  input logic signed [RES_W-1:0] out_temp,
  input logic                    out_nodata
);
  // R7: fixed three-cycle latency in both directions
  p_latency_on_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##3 out_valid);
  p_latency_off_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##3 !out_valid);

  // R8: channel travels with its sample
  p_chan_carry_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_chan == $past(in_chan, 3));

  // R5: no-data flag tracks a zero code, and clears the temperature
  p_nodata_src_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_nodata == ($past(in_code, 3) == '0));
  p_nodata_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_nodata) |-> out_temp == '0);

  // R10: outputs hold between results
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_temp) && $stable(out_chan) && $stable(out_nodata)));
endmodule

bind tcode_xlate tcode_xlate_chk #(
  .CODE_W(CODE_W), .CHAN_W(CHAN_W), .RES_W(RES_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan), .in_code(in_code),
  .out_valid(out_valid), .out_chan(out_chan), .out_temp(out_temp), .out_nodata(out_nodata)
);

// File: tb/sim_tcode_xlate.sv
`timescale 1ns/1ps
module sim_tcode_xlate;
  localparam int CODE_W = 12;
  localparam int CHAN_N = 4;
  localparam int CHAN_W = 2;
  localparam int RES_W  = 32;
  localparam int OFS    = 187744;
  localparam int SCL    = 672;
  localparam int DEV    = 7000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [CHAN_W-1:0] in_chan = '0;
  logic [CODE_W-1:0] in_code = '0;
  logic in_pw = 1'b0;
  logic out_valid;
  logic [CHAN_W-1:0] out_chan;
  logic signed [RES_W-1:0] out_temp;
  logic out_nodata;

  always #2.5 clk = ~clk;

  tcode_xlate #(
    .CODE_W(CODE_W), .CHAN_N(CHAN_N), .RES_W(RES_W),
    .LIN_OFFSET(OFS), .LIN_SCALE(SCL), .DEVIATION(DEV)
  ) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
    .in_code(in_code), .in_pw(in_pw), .out_valid(out_valid),
    .out_chan(out_chan), .out_temp(out_temp), .out_nodata(out_nodata)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;
  bit mon_on = 0;

  int    q_temp[$];
  int    q_chan[$];
  bit    q_nd[$];
  int    q_cyc[$];
  string q_tag[$];

  int  last_temp = 0;
  int  last_chan = 0;
  bit  last_nd   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string msg);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  // Bench-side model of the requirements
  function automatic void model(input int code, input int chan, input bit pw,
                                output int t, output bit nd, output string tag);
    int k, b;
    if (code == 0) begin
      t = 0; nd = 1; tag = "R5"; return;
    end
    nd = 0;
    if (!pw) begin k = SCL; b = OFS; tag = "R1 R6"; end
    else if (code >= 'h500) begin k = 1191; b = 223000; tag = "R2 R6"; end
    else if (chan == 0) begin k = 1452; b = 259000; tag = "R3 R6"; end
    else begin k = 1590; b = 276000; tag = "R4 R6"; end
    t = b - ((code * k) / 10) + DEV;
  endfunction

  task automatic send(input int code, input int chan, input bit pw);
    int t; bit nd; string tag;
    @(negedge clk);
    in_valid = 1'b1;
    in_code  = CODE_W'(code);
    in_chan  = CHAN_W'(chan);
    in_pw    = pw;
    model(code, chan, pw, t, nd, tag);
    q_temp.push_back(t);
    q_chan.push_back(chan);
    q_nd.push_back(nd);
    q_cyc.push_back(cyc + 3);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: results (R1-R8 values) and holding between results (R10)
  always @(negedge clk) begin
    if (mon_on && !done) begin
      if (out_valid) begin
        if (q_temp.size() == 0) begin
          check(0, $sformatf("R7 unexpected result: actual out_valid=1 expected 0 at cycle %0d", cyc));
        end else begin
          int et, ec, ecy; bit en; string tg;
          et = q_temp.pop_front(); ec = q_chan.pop_front();
          en = q_nd.pop_front(); ecy = q_cyc.pop_front(); tg = q_tag.pop_front();
          check(out_temp == et && out_nodata == en,
                $sformatf("%s temp/nodata: actual %0d/%0d expected %0d/%0d", tg, out_temp, out_nodata, et, en));
          check(int'(out_chan) == ec,
                $sformatf("R8 chan: actual %0d expected %0d", out_chan, ec));
          check(cyc == ecy,
                $sformatf("R7 latency: actual cycle %0d expected %0d", cyc, ecy));
        end
        last_temp = out_temp; last_chan = int'(out_chan); last_nd = out_nodata;
      end else begin
        check(out_temp == last_temp && int'(out_chan) == last_chan && out_nodata == last_nd,
              $sformatf("R10 hold: actual %0d/%0d/%0d expected %0d/%0d/%0d",
                        out_temp, out_chan, out_nodata, last_temp, last_chan, last_nd));
      end
    end
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    check(out_valid == 0 && out_nodata == 0 && out_temp == 0 && out_chan == 0,
          $sformatf("R9 in reset: actual v=%0d nd=%0d t=%0d c=%0d expected all 0", out_valid, out_nodata, out_temp, out_chan));
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 0 && out_nodata == 0 && out_temp == 0 && out_chan == 0,
          $sformatf("R9 after reset: actual v=%0d nd=%0d t=%0d c=%0d expected all 0", out_valid, out_nodata, out_temp, out_chan));
    mon_on = 1;
    // Directed edges first: the 0x4FF/0x500 break on both low-range channels
    send('h4FF, 0, 1); send('h500, 0, 1); send('h4FF, 1, 1); send('h500, 3, 1);
    send(0, 2, 1); send(1, 0, 0); send('hFFF, 3, 0);
    idle(3);
    // Exhaustive sweep, with idle gaps
    n = 0;
    for (int pw = 0; pw < 2; pw++)
      for (int ch = 0; ch < CHAN_N; ch++)
        for (int code = 0; code < (1 << CODE_W); code++) begin
          send(code, ch, pw[0]);
          n++;
          if (n % 97 == 0) idle(2);
        end
    idle(6);
    check(q_temp.size() == 0,
          $sformatf("R7 results outstanding: actual %0d expected 0", q_temp.size()));
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule